// File: doc/BRIEF.md
# User-Mode Privilege Trap Controller

This block sits next to a 12-bit accumulator processor and enforces a two-level privilege scheme. In supervisor (monitor) mode everything runs unchecked. In user mode the controller watches each decoded instruction and each data memory access. It flags any instruction that is reserved for the supervisor, and any data access that leaves the user's single 4096-word field. A flagged operation is suppressed in the same cycle and a sticky trap flag is set. The trap is taken only while the interrupt system is enabled. Taking it drops the processor into supervisor mode and presents a fixed entry vector.

All device transfers are reserved for the supervisor. The instructions that switch instruction or data field belong to that class, so user code cannot leave its field by switching fields. The controller also records the program counter and the field registers of the first offending operation, so the supervisor can resume the program or emulate the instruction. On any interrupt entry the mode in force is saved, and a return strobe restores it.

Top module: `prv_trap_ctl`

## Requirements
- R1: After reset the block is in supervisor mode (`user_mode`=0), the trap flag is clear, `trap_req` is 0 and the save register holds zero.
- R2: In supervisor mode no instruction and no data access asserts `suppress` or sets the trap flag.
- R3: In user mode a valid instruction whose bits 11:9 equal 6 (device transfer class, which includes field-change instructions) asserts `suppress` in the same cycle and sets the trap flag at the next edge. Other opcodes (for example bits 11:9 = 1) are legal.
- R4: In user mode an operate instruction with bits 11:8 = 4'b1111 and bit 0 = 0 is illegal when bit 2 (switch-register OR) or bit 1 (halt) is set. Other operate words, such as octal 7440 or octal 7001, are legal.
- R5: In user mode a data access (`mem_req`=1) whose field differs from `cur_ifield` is illegal. An access to the same field is legal.
- R6: While `int_en` is 0 a set trap flag stays set and `trap_req` stays 0.
- R7: When the trap flag is set and `int_en` is 1, `trap_req` is 1 in that cycle. At the next edge the block enters supervisor mode and clears the trap flag. The vector output is field 0, address 1.
- R8: The save register captures `pc_in`, `cur_ifield` and `cur_dfield` of the offense that sets the trap flag. Later offenses while the flag is set leave it unchanged.
- R9: `int_ack` (and a taken trap) saves the current mode and enters supervisor mode. `rti_strobe` restores the saved mode.
- R10: `enter_user` moves supervisor mode to user mode. If `int_ack` arrives in the same cycle, the block stays in supervisor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_valid | input | 1 | `inst_word` holds a newly decoded instruction |
| inst_word | input | 12 | Decoded instruction word |
| mem_req | input | 1 | A data memory access is requested this cycle |
| mem_field | input | 3 | Field targeted by the data access |
| cur_ifield | input | 3 | Current instruction field |
| cur_dfield | input | 3 | Current data field |
| pc_in | input | 12 | Program counter of the current instruction |
| int_en | input | 1 | Interrupt system enabled |
| int_ack | input | 1 | Interrupt entry strobe from another source |
| rti_strobe | input | 1 | Return-from-interrupt strobe |
| enter_user | input | 1 | Supervisor request to switch to user mode |
| suppress | output | 1 | Current instruction or access must not commit |
| trap_req | output | 1 | Trap is being taken this cycle |
| trap_pend | output | 1 | Sticky trap flag |
| user_mode | output | 1 | 1 = user mode, 0 = supervisor mode |
| trap_vec_field | output | 3 | Field of the trap entry vector |
| trap_vec_addr | output | 12 | Address of the trap entry vector |
| sav_pc | output | 12 | Saved program counter of the offender |
| sav_ifield | output | 3 | Saved instruction field |
| sav_dfield | output | 3 | Saved data field |

## Verification
The bound assertions check several rules on every cycle. Supervisor mode is never suppressed. A suppressed operation always leads to a pending flag. A pending flag survives while interrupts are off. A taken trap always lands in supervisor mode with the flag cleared. The save register is frozen while the flag is set. Only the directed scenarios show which exact opcode patterns and field mismatches count as illegal, the vector value, the captured offender fields, and the nesting of mode save and restore across interrupt entry and return.

// File: rtl/prv_trap_pkg.sv
package prv_trap_pkg;
   // opcode class that covers every device transfer, field switches included
   localparam logic [2:0] OPC_DEVICE  = 3'd6;
   // leading nibble of a second-group operate word
   localparam logic [3:0] OPR_GRP2    = 4'hF;
   localparam int         BIT_SWOR    = 2;
   localparam int         BIT_HALT    = 1;
   localparam int         BIT_GRPSEL  = 0;
   localparam int         OPC_W       = 3;

   typedef struct packed {
      logic instr_bad;
      logic field_bad;
   } prv_cause_t;
endpackage

// File: rtl/prv_op_decode.sv
module prv_op_decode
   import prv_trap_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              inst_valid,
   input  logic [WORD_W-1:0] inst_word,
   output logic              priv_op
);
   localparam int OPC_LSB = WORD_W - OPC_W;

   logic is_dev;
   logic is_grp2;
   logic grp2_priv;

   always_comb begin
      is_dev    = (inst_word[WORD_W-1:OPC_LSB] == OPC_DEVICE);
      is_grp2   = (inst_word[WORD_W-1:WORD_W-4] == OPR_GRP2) && !inst_word[BIT_GRPSEL];
      grp2_priv = is_grp2 && (inst_word[BIT_SWOR] || inst_word[BIT_HALT]);
      priv_op   = inst_valid && (is_dev || grp2_priv);
   end
endmodule

// File: rtl/prv_field_guard.sv
module prv_field_guard #(
   parameter int FIELD_W = 3,
   parameter bit CONFINE = 1'b1
) (
   input  logic               mem_req,
   input  logic [FIELD_W-1:0] mem_field,
   input  logic [FIELD_W-1:0] home_field,
   output logic               breach
);
   generate
      if (CONFINE) begin : g_confine
         always_comb breach = mem_req && (mem_field != home_field);
      end else begin : g_open
         always_comb breach = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/prv_mode_ctl.sv
module prv_mode_ctl
   import prv_trap_pkg::*;
#(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  prv_cause_t         cause,
   input  logic [WORD_W-1:0]  pc_in,
   input  logic [FIELD_W-1:0] cur_ifield,
   input  logic [FIELD_W-1:0] cur_dfield,
   input  logic               int_en,
   input  logic               int_ack,
   input  logic               rti_strobe,
   input  logic               enter_user,
   output logic               user_mode,
   output logic               trap_pend,
   output logic               take,
   output logic               offend,
   output logic [WORD_W-1:0]  sav_pc,
   output logic [FIELD_W-1:0] sav_ifield,
   output logic [FIELD_W-1:0] sav_dfield
);
   logic mode_saved;

   always_comb begin
      offend = user_mode && (cause.instr_bad || cause.field_bad);
      take   = trap_pend && int_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_mode  <= 1'b0;
         mode_saved <= 1'b0;
      end else if (take || int_ack) begin
         mode_saved <= user_mode;
         user_mode  <= 1'b0;
      end else if (rti_strobe) begin
         user_mode  <= mode_saved;
      end else if (enter_user && !user_mode) begin
         user_mode  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trap_pend <= 1'b0;
      else if (take)   trap_pend <= 1'b0;
      else if (offend) trap_pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sav_pc     <= '0;
         sav_ifield <= '0;
         sav_dfield <= '0;
      end else if (offend && !trap_pend) begin
         sav_pc     <= pc_in;
         sav_ifield <= cur_ifield;
         sav_dfield <= cur_dfield;
      end
   end
endmodule

// File: rtl/prv_trap_ctl.sv
module prv_trap_ctl
   import prv_trap_pkg::*;
#(
   parameter int WORD_W    = 12,
   parameter int FIELD_W   = 3,
   parameter int VEC_FIELD = 0,
   parameter int VEC_ADDR  = 1,
   parameter bit CONFINE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inst_valid,
   input  logic [WORD_W-1:0]  inst_word,
   input  logic               mem_req,
   input  logic [FIELD_W-1:0] mem_field,
   input  logic [FIELD_W-1:0] cur_ifield,
   input  logic [FIELD_W-1:0] cur_dfield,
   input  logic [WORD_W-1:0]  pc_in,
   input  logic               int_en,
   input  logic               int_ack,
   input  logic               rti_strobe,
   input  logic               enter_user,
   output logic               suppress,
   output logic               trap_req,
   output logic               trap_pend,
   output logic               user_mode,
   output logic [FIELD_W-1:0] trap_vec_field,
   output logic [WORD_W-1:0]  trap_vec_addr,
   output logic [WORD_W-1:0]  sav_pc,
   output logic [FIELD_W-1:0] sav_ifield,
   output logic [FIELD_W-1:0] sav_dfield
);
   localparam int NUM_FIELDS = 1 << FIELD_W;

   generate
      if (WORD_W != 12) begin : g_bad_word
         $error("prv_trap_ctl: decode needs a 12-bit word");
      end
      if (VEC_FIELD >= NUM_FIELDS) begin : g_bad_vfield
         $error("prv_trap_ctl: vector field out of range");
      end
      if (VEC_ADDR >= (1 << WORD_W)) begin : g_bad_vaddr
         $error("prv_trap_ctl: vector address out of range");
      end
   endgenerate

   prv_cause_t cause;
   logic       priv_op;
   logic       breach;
   logic       take;
   logic       offend;

   prv_op_decode #(.WORD_W(WORD_W)) dec_i (
      .inst_valid (inst_valid),
      .inst_word  (inst_word),
      .priv_op    (priv_op)
   );

   prv_field_guard #(.FIELD_W(FIELD_W), .CONFINE(CONFINE)) fg_i (
      .mem_req    (mem_req),
      .mem_field  (mem_field),
      .home_field (cur_ifield),
      .breach     (breach)
   );

   always_comb begin
      cause.instr_bad = priv_op;
      cause.field_bad = breach;
   end

   prv_mode_ctl #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) mc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cause      (cause),
      .pc_in      (pc_in),
      .cur_ifield (cur_ifield),
      .cur_dfield (cur_dfield),
      .int_en     (int_en),
      .int_ack    (int_ack),
      .rti_strobe (rti_strobe),
      .enter_user (enter_user),
      .user_mode  (user_mode),
      .trap_pend  (trap_pend),
      .take       (take),
      .offend     (offend),
      .sav_pc     (sav_pc),
      .sav_ifield (sav_ifield),
      .sav_dfield (sav_dfield)
   );

   always_comb begin
      suppress       = offend;
      trap_req       = take;
      trap_vec_field = FIELD_W'(VEC_FIELD);
      trap_vec_addr  = WORD_W'(VEC_ADDR);
   end
endmodule

// File: rtl/prv_trap_chk.sv
module prv_trap_chk #(
   parameter int WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_en,
   input logic              int_ack,
   input logic              rti_strobe,
   input logic              enter_user,
   input logic              suppress,
   input logic              trap_req,
   input logic              trap_pend,
   input logic              user_mode,
   input logic [WORD_W-1:0] sav_pc
);
   // R2: supervisor mode is never suppressed
   a_r2_monitor_free: assert property (@(posedge clk) disable iff (!rst_n)
      !user_mode |-> !suppress);

   // R3: a suppressed operation leaves the trap flag set unless a trap is taken now
   a_r3_suppress_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (suppress && !trap_req) |=> trap_pend);

   // R6: the flag holds while interrupts are off
   a_r6_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pend && !int_en) |=> trap_pend);

   // R6: no trap request without interrupts enabled
   a_r6_no_req_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !trap_req);

   // R7: a taken trap lands in supervisor mode with the flag cleared
   a_r7_take_lands: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (!user_mode && !trap_pend));

   // R8: the save register is frozen while a trap is pending
   a_r8_save_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pend |=> $stable(sav_pc));

   // R9: interrupt entry always lands in supervisor mode
   a_r9_entry_monitor: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !user_mode);

   // R10: an uncontested enter request from supervisor mode reaches user mode
   a_r10_enter_user: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_user && !user_mode && !int_ack && !rti_strobe && !trap_req) |=> user_mode);
endmodule

bind prv_trap_ctl prv_trap_chk #(.WORD_W(WORD_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .int_en     (int_en),
   .int_ack    (int_ack),
   .rti_strobe (rti_strobe),
   .enter_user (enter_user),
   .suppress   (suppress),
   .trap_req   (trap_req),
   .trap_pend  (trap_pend),
   .user_mode  (user_mode),
   .sav_pc     (sav_pc)
);

// File: tb/prv_trap_ctl_tb.sv
`timescale 1ns/1ps
module prv_trap_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inst_valid = 1'b0;
   logic [11:0] inst_word = '0;
   logic        mem_req = 1'b0;
   logic [2:0]  mem_field = 3'd1;
   logic [2:0]  cur_ifield = 3'd1;
   logic [2:0]  cur_dfield = 3'd3;
   logic [11:0] pc_in = '0;
   logic        int_en = 1'b0;
   logic        int_ack = 1'b0;
   logic        rti_strobe = 1'b0;
   logic        enter_user = 1'b0;
   logic        suppress, trap_req, trap_pend, user_mode;
   logic [2:0]  trap_vec_field, sav_ifield, sav_dfield;
   logic [11:0] trap_vec_addr, sav_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // staged stimulus, applied by tick()
   logic        s_iv = 0, s_mr = 0, s_ie = 0, s_ack = 0, s_rti = 0, s_ent = 0;
   logic [11:0] s_w = '0, s_pc = '0;
   logic [2:0]  s_mf = 3'd1;

   // scoreboard of post-edge expectations
   logic  exp_u_q[$];
   logic  exp_p_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   prv_trap_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_word(inst_word),
      .mem_req(mem_req), .mem_field(mem_field), .cur_ifield(cur_ifield),
      .cur_dfield(cur_dfield), .pc_in(pc_in), .int_en(int_en), .int_ack(int_ack),
      .rti_strobe(rti_strobe), .enter_user(enter_user), .suppress(suppress),
      .trap_req(trap_req), .trap_pend(trap_pend), .user_mode(user_mode),
      .trap_vec_field(trap_vec_field), .trap_vec_addr(trap_vec_addr),
      .sav_pc(sav_pc), .sav_ifield(sav_ifield), .sav_dfield(sav_dfield)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic e_sup, input logic e_req, input logic e_u,
                       input logic e_p, input string tag);
      @(negedge clk);
      inst_valid = s_iv; inst_word = s_w; mem_req = s_mr; mem_field = s_mf;
      pc_in = s_pc; int_en = s_ie; int_ack = s_ack; rti_strobe = s_rti;
      enter_user = s_ent;
      #1;
      check({tag, " suppress"}, 32'(suppress), 32'(e_sup));
      check({tag, " trap_req"}, 32'(trap_req), 32'(e_req));
      exp_u_q.push_back(e_u);
      exp_p_q.push_back(e_p);
      tag_q.push_back(tag);
      s_iv = 0; s_w = '0; s_mr = 0; s_mf = 3'd1; s_ie = 0; s_ack = 0;
      s_rti = 0; s_ent = 0;
   endtask

   // monitor: compare state after each active edge
   always @(posedge clk) begin
      #1;
      if (exp_u_q.size() > 0) begin
         logic  eu, ep;
         string t;
         eu = exp_u_q.pop_front();
         ep = exp_p_q.pop_front();
         t  = tag_q.pop_front();
         check({t, " user_mode"}, 32'(user_mode), 32'(eu));
         check({t, " trap_pend"}, 32'(trap_pend), 32'(ep));
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 user_mode", 32'(user_mode), 0);
      check("R1 trap_pend", 32'(trap_pend), 0);
      check("R1 trap_req", 32'(trap_req), 0);
      check("R1 sav_pc", 32'(sav_pc), 0);

      // R2 supervisor mode: device op and foreign access pass
      s_iv = 1; s_w = 12'o6032; s_ie = 1; tick(0, 0, 0, 0, "R2 dev op");
      s_mr = 1; s_mf = 3'd5;               tick(0, 0, 0, 0, "R2 far access");
      // R10 entry collides with interrupt entry
      s_ent = 1; s_ack = 1;                tick(0, 0, 0, 0, "R10 ack wins");
      s_ent = 1;                           tick(0, 0, 1, 0, "R10 enter");
      // legal user work
      s_iv = 1; s_w = 12'o1234;            tick(0, 0, 1, 0, "R3 legal opcode");
      s_iv = 1; s_w = 12'o7440;            tick(0, 0, 1, 0, "R4 legal grp2");
      s_iv = 1; s_w = 12'o7001;            tick(0, 0, 1, 0, "R4 legal grp1");
      s_mr = 1; s_mf = 3'd1;               tick(0, 0, 1, 0, "R5 home access");
      // R4 halt, held while interrupts off
      s_iv = 1; s_w = 12'o7402; s_pc = 12'o0100; tick(1, 0, 1, 1, "R4 halt");
      tick(0, 0, 1, 1, "R6 held");
      // R3 second offender while pending
      s_iv = 1; s_w = 12'o6032; s_pc = 12'o0200; tick(1, 0, 1, 1, "R3 dev op");
      s_ie = 1;                            tick(0, 1, 0, 0, "R7 take");
      check("R7 vec field", 32'(trap_vec_field), 0);
      check("R7 vec addr", 32'(trap_vec_addr), 1);
      check("R8 sav_pc first", 32'(sav_pc), 32'(12'o0100));
      check("R8 sav_ifield", 32'(sav_ifield), 1);
      check("R8 sav_dfield", 32'(sav_dfield), 3);
      // R4 switch-register OR with interrupts on
      s_ent = 1;                           tick(0, 0, 1, 0, "R10 re-enter");
      s_iv = 1; s_w = 12'o7404; s_ie = 1; s_pc = 12'o0300; tick(1, 0, 1, 1, "R4 swor");
      s_ie = 1;                            tick(0, 1, 0, 0, "R7 take2");
      check("R8 sav_pc new", 32'(sav_pc), 32'(12'o0300));
      // R5 foreign field
      s_ent = 1;                           tick(0, 0, 1, 0, "R10 re-enter2");
      s_mr = 1; s_mf = 3'd2;               tick(1, 0, 1, 1, "R5 foreign");
      s_ie = 1;                            tick(0, 1, 0, 0, "R7 take3");
      // R9 save/restore nesting
      s_ent = 1;                           tick(0, 0, 1, 0, "R10 re-enter3");
      s_ack = 1;                           tick(0, 0, 0, 0, "R9 ack user");
      s_rti = 1;                           tick(0, 0, 1, 0, "R9 rti to user");
      s_ack = 1;                           tick(0, 0, 0, 0, "R9 ack user2");
      s_ack = 1;                           tick(0, 0, 0, 0, "R9 ack monitor");
      s_rti = 1;                           tick(0, 0, 0, 0, "R9 rti to monitor");
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule